// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block holds the hazard decisions of a five-stage in-order integer pipeline. Each cycle it looks at the source register numbers of the instruction in execute. It compares them with the destinations of the two older instructions still in flight, which sit in the memory-stage and writeback-stage pipeline registers. For each ALU input it returns a 2-bit select that says where the operand comes from: the value read from the register file, the result in the memory-stage register, or the result in the writeback-stage register. When both older instructions write the matching register, the newer result, in the memory-stage register, wins.

Forwarding cannot cover a load whose data is needed by the very next instruction. For that case the block also compares the load's destination, held in execute, with the two source numbers of the instruction in decode. On a match it raises a one-cycle interlock: the program counter and the fetch/decode latch hold their values, and the control fields entering execute are replaced by a no-operation while the load moves on. After that single bubble the loaded value is one stage further down, and the writeback-stage forwarding path supplies it. The block is purely combinational, with no state. The register file writes in the first half of a cycle and reads in the second half, so a result three instructions older never needs a bypass.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: `fwd_sel_a` is 2'd1 whenever `mem_wr_en` is 1, `mem_dst` is nonzero and `mem_dst` equals `exe_src_a`.
- R2: `fwd_sel_b` follows the R1 rule, with `exe_src_b` in place of `exe_src_a`.
- R3: A select is 2'd2 when `wb_wr_en` is 1, `wb_dst` is nonzero, `wb_dst` equals that operand's source, and the R1/R2 condition for that operand is false.
- R4: When both the memory-stage and the writeback-stage destinations match an operand, its select is 2'd1 (the newer result has priority).
- R5: When neither stage matches, the select is 2'd0 (the register file value). The code 2'd3 never appears.
- R6: Register 0 never causes forwarding: a source of 0 always yields select 2'd0, even when a stage has write enable set with destination 0.
- R7: The interlock fires when `exe_is_load` and `exe_wr_en` are both 1, `exe_dst` is nonzero, and `exe_dst` equals `dec_src_a` or `dec_src_b`. During the interlock `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1.
- R8: In every other case `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0. This includes a non-load that matches, a load without write enable, and a load to register 0.
- R9: All outputs follow the inputs in the same cycle, without waiting for a clock edge.
- R10: A load-use pair stalls for exactly one cycle. In the cycle after the bubble no interlock is raised. One cycle later the dependent instruction's operand selects 2'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 5 | First source register of the instruction in decode |
| dec_src_b | input | 5 | Second source register of the instruction in decode |
| exe_src_a | input | 5 | First source register of the instruction in execute |
| exe_src_b | input | 5 | Second source register of the instruction in execute |
| exe_dst | input | 5 | Destination register of the instruction in execute |
| exe_wr_en | input | 1 | Instruction in execute writes a register |
| exe_is_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | 5 | Destination held in the memory-stage register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination held in the writeback-stage register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| fwd_sel_a | output | 2 | ALU input A source: 0 register file, 1 memory stage, 2 writeback stage |
| fwd_sel_b | output | 2 | ALU input B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| idex_bubble | output | 1 | Replace control fields entering execute with a no-operation |

## Verification
The hardest case to reach is the full load-use sequence across consecutive cycles. The interlock, the empty bubble in execute, and the later writeback-stage bypass only form a consistent picture when the port values advance the way a real pipeline shifts. The bench therefore contains a small shift model of decode, execute, memory and writeback that walks a load and its consumer through three cycles. Random stimulus draws register numbers from a narrow range, so double matches and register-0 destinations with write enable set come up often.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        OPSEL_REGFILE = 2'd0,
        OPSEL_MEMSTG  = 2'd1,
        OPSEL_WBSTG   = 2'd2
    } opsel_e;

endpackage

// File: rtl/hz_operand_bypass.sv
module hz_operand_bypass #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       sel
);
    import hz_pkg::*;

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic   mem_hit;
    logic   wb_hit;
    opsel_e pick;

    always_comb begin
        mem_hit = mem_wr && (mem_dst != ZERO_IDX) && (mem_dst == src);
        wb_hit  = wb_wr  && (wb_dst  != ZERO_IDX) && (wb_dst  == src);
        unique casez ({mem_hit, wb_hit})
            2'b1?:   pick = OPSEL_MEMSTG;
            2'b01:   pick = OPSEL_WBSTG;
            default: pick = OPSEL_REGFILE;
        endcase
        sel = pick;
    end

    always_comb begin
        if (!$isunknown({src, mem_dst, mem_wr, wb_dst, wb_wr})) begin
            p_zero_never_fwd_r6: assert (src != ZERO_IDX || sel == 2'd0);
            p_newer_wins_r4: assert (!(mem_wr && mem_dst == src && src != ZERO_IDX) || sel == 2'd1);
            p_code_legal_r5: assert (sel != 2'd3);
        end
    end

endmodule

// File: rtl/hz_load_use_detect.sv
module hz_load_use_detect #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] dec_src_a,
    input  logic [IDX_W-1:0] dec_src_b,
    input  logic [IDX_W-1:0] exe_dst,
    input  logic             exe_wr,
    input  logic             exe_load,
    output logic             stall
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic live_load;

    always_comb begin
        live_load = exe_load && exe_wr && (exe_dst != ZERO_IDX);
        stall     = live_load && ((exe_dst == dec_src_a) || (exe_dst == dec_src_b));
    end

    always_comb begin
        if (!$isunknown({dec_src_a, dec_src_b, exe_dst, exe_wr, exe_load})) begin
            p_nonload_free_r8: assert (exe_load || !stall);
        end
    end

endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit (
    input  logic [4:0] dec_src_a,
    input  logic [4:0] dec_src_b,
    input  logic [4:0] exe_src_a,
    input  logic [4:0] exe_src_b,
    input  logic [4:0] exe_dst,
    input  logic       exe_wr_en,
    input  logic       exe_is_load,
    input  logic [4:0] mem_dst,
    input  logic       mem_wr_en,
    input  logic [4:0] wb_dst,
    input  logic       wb_wr_en,
    output logic [1:0] fwd_sel_a,
    output logic [1:0] fwd_sel_b,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       idex_bubble
);
    localparam int IDX_W   = 5;
    localparam int N_OPERS = 2;

    logic [N_OPERS-1:0][IDX_W-1:0] opr_src;
    logic [N_OPERS-1:0][1:0]       opr_sel;
    logic                          hold_front;

    assign opr_src[0] = exe_src_a;
    assign opr_src[1] = exe_src_b;

    for (genvar g = 0; g < N_OPERS; g++) begin : g_opr
        hz_operand_bypass #(.IDX_W(IDX_W)) u_byp (
            .src     (opr_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr_en),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr_en),
            .sel     (opr_sel[g])
        );
    end

    hz_load_use_detect #(.IDX_W(IDX_W)) u_lud (
        .dec_src_a (dec_src_a),
        .dec_src_b (dec_src_b),
        .exe_dst   (exe_dst),
        .exe_wr    (exe_wr_en),
        .exe_load  (exe_is_load),
        .stall     (hold_front)
    );

    assign fwd_sel_a   = opr_sel[0];
    assign fwd_sel_b   = opr_sel[1];
    assign pc_we       = !hold_front;
    assign ifid_we     = !hold_front;
    assign idex_bubble = hold_front;

    always_comb begin
        if (!$isunknown({pc_we, ifid_we, idex_bubble, exe_is_load})) begin
            p_freeze_group_r7: assert (!idex_bubble || (!pc_we && !ifid_we && exe_is_load));
        end
    end

endmodule

// File: tb/hazard_ctrl_unit_tb.sv
module hazard_ctrl_unit_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [4:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst;
    logic       exe_wr_en, exe_is_load, mem_wr_en, wb_wr_en;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       pc_we, ifid_we, idex_bubble;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    hazard_ctrl_unit u_dut (
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
        .exe_dst(exe_dst), .exe_wr_en(exe_wr_en), .exe_is_load(exe_is_load),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
    );

    function automatic logic [1:0] exp_sel(logic [4:0] s, logic [4:0] md, logic mw,
                                           logic [4:0] wd, logic ww);
        if (s == 5'd0) return 2'd0;
        if (mw && md == s) return 2'd1;
        if (ww && wd == s) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic exp_stall(logic [4:0] da, logic [4:0] db, logic [4:0] ed,
                                       logic ew, logic el);
        return el && ew && ed != 5'd0 && (ed == da || ed == db);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic st;
        st = exp_stall(dec_src_a, dec_src_b, exe_dst, exe_wr_en, exe_is_load);
        chk({req, " sel_a"}, {6'd0, fwd_sel_a}, {6'd0, exp_sel(exe_src_a, mem_dst, mem_wr_en, wb_dst, wb_wr_en)});
        chk({req, " sel_b"}, {6'd0, fwd_sel_b}, {6'd0, exp_sel(exe_src_b, mem_dst, mem_wr_en, wb_dst, wb_wr_en)});
        chk({req, " stall"}, {5'd0, pc_we, ifid_we, idex_bubble}, {5'd0, !st, !st, st});
    endtask

    task automatic drive(logic [4:0] da, logic [4:0] db, logic [4:0] ea, logic [4:0] eb,
                         logic [4:0] ed, logic ew, logic el, logic [4:0] md, logic mw,
                         logic [4:0] wd, logic ww);
        @(negedge clk);
        dec_src_a = da; dec_src_b = db; exe_src_a = ea; exe_src_b = eb;
        exe_dst = ed; exe_wr_en = ew; exe_is_load = el;
        mem_dst = md; mem_wr_en = mw; wb_dst = wd; wb_wr_en = ww;
        #5;
    endtask

    initial begin
        dec_src_a = 0; dec_src_b = 0; exe_src_a = 0; exe_src_b = 0; exe_dst = 0;
        exe_wr_en = 0; exe_is_load = 0; mem_dst = 0; mem_wr_en = 0; wb_dst = 0; wb_wr_en = 0;
        #5;
        // Idle state: nothing in flight
        chk("R5 idle sel_a", {6'd0, fwd_sel_a}, 8'd0);
        chk("R8 idle pc_we", {7'd0, pc_we}, 8'd1);

        // R1 / R2: memory stage matches both operands
        drive(0, 0, 5'd3, 5'd3, 0, 0, 0, 5'd3, 1, 0, 0);
        chk("R1 sel_a", {6'd0, fwd_sel_a}, 8'd1);
        chk("R2 sel_b", {6'd0, fwd_sel_b}, 8'd1);
        // R3: writeback only
        drive(0, 0, 5'd7, 5'd9, 0, 0, 0, 5'd4, 1, 5'd7, 1);
        chk("R3 sel_a", {6'd0, fwd_sel_a}, 8'd2);
        chk("R5 sel_b", {6'd0, fwd_sel_b}, 8'd0);
        // R4: both stages match, newer wins
        drive(0, 0, 5'd5, 5'd5, 0, 0, 0, 5'd5, 1, 5'd5, 1);
        chk("R4 sel_a", {6'd0, fwd_sel_a}, 8'd1);
        // R3: memory stage match without write enable, writeback used
        drive(0, 0, 5'd5, 5'd6, 0, 0, 0, 5'd5, 0, 5'd5, 1);
        chk("R3 sel_a memwr0", {6'd0, fwd_sel_a}, 8'd2);
        // R6: register 0 with write enable set
        drive(0, 0, 5'd0, 5'd0, 0, 0, 0, 5'd0, 1, 5'd0, 1);
        chk("R6 sel_a", {6'd0, fwd_sel_a}, 8'd0);
        chk("R6 sel_b", {6'd0, fwd_sel_b}, 8'd0);
        // R7: load-use on decode source b
        drive(5'd1, 5'd8, 0, 0, 5'd8, 1, 1, 0, 0, 0, 0);
        chk("R7 freeze", {5'd0, pc_we, ifid_we, idex_bubble}, 8'b001);
        // R8: non-load match, load to r0, load without write enable
        drive(5'd8, 5'd2, 0, 0, 5'd8, 1, 0, 0, 0, 0, 0);
        chk("R8 nonload", {5'd0, pc_we, ifid_we, idex_bubble}, 8'b110);
        drive(5'd0, 5'd0, 0, 0, 5'd0, 1, 1, 0, 0, 0, 0);
        chk("R8 load r0", {5'd0, pc_we, ifid_we, idex_bubble}, 8'b110);
        drive(5'd4, 5'd4, 0, 0, 5'd4, 0, 1, 0, 0, 0, 0);
        chk("R8 load nowr", {5'd0, pc_we, ifid_we, idex_bubble}, 8'b110);

        // R9: outputs follow inputs without a clock edge
        @(posedge clk); #2;
        exe_src_a = 5'd12; mem_dst = 5'd12; mem_wr_en = 1'b1;
        #1;
        chk("R9 same cycle", {6'd0, fwd_sel_a}, 8'd1);

        // R10: load r9 then dependent consumer; three pipeline steps
        drive(5'd9, 5'd2, 5'd1, 5'd1, 5'd9, 1, 1, 0, 0, 0, 0);
        chk("R10 step1 stall", {7'd0, idex_bubble}, 8'd1);
        drive(5'd9, 5'd2, 0, 0, 0, 0, 0, 5'd9, 1, 0, 0);
        chk("R10 step2 no stall", {7'd0, idex_bubble}, 8'd0);
        drive(5'd3, 5'd3, 5'd9, 5'd2, 5'd3, 1, 0, 0, 0, 5'd9, 1);
        chk("R10 step3 wb bypass", {6'd0, fwd_sel_a}, 8'd2);

        // Constrained random: narrow register range
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 600; i++) begin
            drive($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
                  1'($urandom), 1'($urandom), $urandom % 4, 1'($urandom), $urandom % 4,
                  1'($urandom));
            check_all("R1 R2 R3 R4 R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule